// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Signed Compare

This block is a purely combinational integer arithmetic and logic unit for a datapath of parameterised width (32 bits by default). It is a chain of identical one-bit slices. Every slice forms the bitwise AND, the bitwise OR and a full-adder sum of its operand bits in parallel. A small per-slice multiplexer then picks one of those results, or a "less" input. Carries ripple from the least significant slice upward.

Subtraction and the signed less-than compare reuse the same adder. The operation code asks for the second operand to be inverted and for a carry of one to enter the lowest slice. For the compare, the top level takes the sum bit of the sign slice, corrects it with the overflow flag, and feeds the result back into the "less" input of bit 0. Every other "less" input is tied low. A zero flag, a signed-overflow flag and the adder's carry-out are produced for every operation. A branch on equality can therefore subtract and look at the zero flag.

The caller places the block between operand registers and a result register. It has no clock and no internal state. The result settles one carry-chain delay after the inputs change.

Top module: `ripple_slt_alu`

## Requirements
- R1: Operation code 3'b000 gives result = a AND b.
- R2: Operation code 3'b001 gives result = a OR b.
- R3: Operation code 3'b010 gives result = a + b modulo 2^W. For every operation code, carry_o is the carry out of the most significant adder bit, where the adder computes a + (op[2] ? ~b : b) + op[2].
- R4: Operation code 3'b110 gives result = a - b modulo 2^W, formed as a + ~b + 1. The carry-out is therefore 1 exactly when a >= b as unsigned numbers.
- R5: Operation code 3'b111 gives result = 1 when a < b as signed two's-complement numbers, and 0 otherwise. Bits W-1..1 are always 0. The compare stays correct when a - b overflows.
- R6: Operation codes 3'b011, 3'b100 and 3'b101 give a result of all zeros.
- R7: zero_o is 1 exactly when every result bit is 0.
- R8: overflow_o is the signed overflow of the adder under the current invert setting (carry into the sign bit XOR carry out of it), for every operation code. Addition of operands with different signs never sets it. Subtraction of operands with equal signs never sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W (32) | First operand |
| b_i | input | W (32) | Second operand, inverted inside the slices when op_i[2] is 1 |
| op_i | input | 3 | Operation code; bit 2 also selects invert-and-carry-in |
| result_o | output | W (32) | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |
| overflow_o | output | 1 | Signed overflow of the adder |
| carry_o | output | 1 | Carry out of the most significant slice |

## Verification
The embedded assertions compare each operation's result directly against the arithmetic or logic it should equal. They also tie the zero flag to equality under subtraction and check the sign rules for when overflow may appear. All of these are evaluated each time the inputs change. The bench covers what these per-code properties cannot show together: the exact carry-out and overflow values on chosen boundary operands. Examples are the largest positive value plus one, the most negative value minus one, and a compare of the two extremes whose difference overflows. It also drives every code, including the unused ones, with random operands against an independent model.

// File: rtl/ripple_alu_pkg.sv
// Package: shared operation codes and slice-select encodings for the ripple ALU.
// Assumes: op[2] doubles as the invert-b / carry-in request; op[1:0] selects the slice result.
package ripple_alu_pkg;

    // Operation codes seen at the top-level port.
    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    // Per-slice output multiplexer select.
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

endpackage

// File: rtl/alu_slice.sv
// Module: one bit of the ALU. AND, OR and a full-adder sum are formed in
// parallel, and the select picks one of them or the external "less" bit.
// Assumes: b inversion is applied here, so every slice sees the same control.
module alu_slice
    import ripple_alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       binv_i,
    input  logic       cin_i,
    input  logic       less_i,
    input  slice_sel_e sel_i,
    output logic       res_o,
    output logic       cout_o
);

    logic b_eff;
    logic sum_bit;

    // Form the possibly inverted operand and the full-adder outputs.
    always_comb begin
        b_eff   = b_i ^ binv_i;
        sum_bit = a_i ^ b_eff ^ cin_i;
        cout_o  = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
    end

    // Output multiplexer over the parallel results.
    always_comb begin
        unique case (sel_i)
            SEL_AND:  res_o = a_i & b_eff;
            SEL_OR:   res_o = a_i | b_eff;
            SEL_SUM:  res_o = sum_bit;
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_op_decode.sv
// Module: splits the 3-bit operation code into the invert request, the slice
// select and a flag that marks the code as defined.
// Assumes: undefined codes are forced to a zero result by the caller.
module alu_op_decode
    import ripple_alu_pkg::*;
(
    input  logic [2:0] op_i,
    output logic       binv_o,
    output slice_sel_e sel_o,
    output logic       valid_o
);

    // Decode the code fields and recognise the five defined operations.
    always_comb begin
        binv_o = op_i[2];
        sel_o  = slice_sel_e'(op_i[1:0]);
        unique case (op_i)
            OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT: valid_o = 1'b1;
            default:                               valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_zero_detect.sv
// Module: wide NOR that reports an all-zero result vector.
// Assumes: the input is the final, already gated result.
module alu_zero_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec_i,
    output logic         zero_o
);

    // Reduce all bits to a single "nothing set" flag.
    always_comb begin
        zero_o = ~(|vec_i);
    end

endmodule

// File: rtl/ripple_slt_alu.sv
// Module: W-bit ripple-carry ALU built from identical slices. It supports AND,
// OR, ADD, SUB and signed set-less-than, and reports zero, overflow and carry.
// Assumes: purely combinational; undefined codes yield a zero result. The flags
// come from the adder for every code.
module ripple_slt_alu
    import ripple_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   op_i,
    output logic [W-1:0] result_o,
    output logic         zero_o,
    output logic         overflow_o,
    output logic         carry_o
);

    localparam int MSB = W - 1;

    logic           binv;
    slice_sel_e     sel;
    logic           op_valid;
    logic [W:0]     carry;
    logic [W-1:0]   less_vec;
    logic [W-1:0]   slice_res;
    logic           msb_sum;
    logic           set_bit;

    alu_op_decode u_dec (
        .op_i    (op_i),
        .binv_o  (binv),
        .sel_o   (sel),
        .valid_o (op_valid)
    );

    // Carry into the lowest slice equals the invert request (two's-complement negate).
    always_comb begin
        carry[0] = binv;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        alu_slice u_slice (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .binv_i (binv),
            .cin_i  (carry[i]),
            .less_i (less_vec[i]),
            .sel_i  (sel),
            .res_o  (slice_res[i]),
            .cout_o (carry[i+1])
        );
    end

    // Sign-slice sum corrected by overflow gives the compare result fed to bit 0.
    always_comb begin
        overflow_o = carry[MSB] ^ carry[W];
        carry_o    = carry[W];
        msb_sum    = a_i[MSB] ^ b_i[MSB] ^ binv ^ carry[MSB];
        set_bit    = msb_sum ^ overflow_o;
        less_vec   = {{(W-1){1'b0}}, set_bit};
    end

    // Force undefined operation codes to a zero result.
    always_comb begin
        result_o = op_valid ? slice_res : '0;
    end

    alu_zero_detect #(.W(W)) u_zero (
        .vec_i  (result_o),
        .zero_o (zero_o)
    );

    // Checks relating the output ports to the operand values.
    always_comb begin
        if (!$isunknown({a_i, b_i, op_i})) begin
            if (op_i == OP_AND)
                assert_and_R1: assert (result_o == (a_i & b_i))
                    else $error("R1 AND result mismatch");
            if (op_i == OP_OR)
                assert_or_R2: assert (result_o == (a_i | b_i))
                    else $error("R2 OR result mismatch");
            if (op_i == OP_ADD)
                assert_add_R3: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}))
                    else $error("R3 ADD sum or carry mismatch");
            if (op_i == OP_SUB)
                assert_sub_R4: assert (result_o == (a_i - b_i) && carry_o == (a_i >= b_i))
                    else $error("R4 SUB difference or carry mismatch");
            if (op_i == OP_SLT)
                assert_slt_R5: assert (result_o == W'($signed(a_i) < $signed(b_i)))
                    else $error("R5 signed compare mismatch");
            if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
                assert_undef_R6: assert (result_o == '0)
                    else $error("R6 undefined code gave nonzero result");
            if (op_i == OP_SUB)
                assert_zero_R7: assert (zero_o == (a_i == b_i))
                    else $error("R7 zero flag disagrees with equality");
            if ((op_i == OP_ADD && a_i[MSB] != b_i[MSB]) ||
                (op_i == OP_SUB && a_i[MSB] == b_i[MSB]))
                assert_no_overflow_R8: assert (!overflow_o)
                    else $error("R8 overflow raised for impossible sign pattern");
        end
    end

endmodule

// File: tb/ripple_slt_alu_tb.sv
// Bench: scoreboard. The driver pushes expected values; the monitor pops and compares at the falling edge.
module ripple_slt_alu_tb_top;

    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n;
    always #4 clk = ~clk;   // 125 MHz

    logic [W-1:0] a, b, res;
    logic [2:0]   op;
    logic         zero, ovf, cout;

    ripple_slt_alu #(.W(W)) dut_i (
        .a_i        (a),
        .b_i        (b),
        .op_i       (op),
        .result_o   (res),
        .zero_o     (zero),
        .overflow_o (ovf),
        .carry_o    (cout)
    );

    typedef struct {
        logic [2:0]   op;
        logic [W-1:0] res;
        logic         z, v, c;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    fails  = 0;

    // Compare one observed value against its expectation.
    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one vector and push the model's expectation.
    task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv, input logic [2:0] ov);
        item_t        it;
        logic [W-1:0] bb;
        logic [W-1:0] s;
        logic         c;
        @(posedge clk);
        #1;
        a  = av;
        b  = bv;
        op = ov;
        bb = ov[2] ? ~bv : bv;
        {c, s} = {1'b0, av} + {1'b0, bb} + {{W{1'b0}}, ov[2]};
        it.op = ov;
        it.c  = c;
        it.v  = (av[W-1] == bb[W-1]) && (s[W-1] != av[W-1]);
        case (ov)
            3'b000:  it.res = av & bv;
            3'b001:  it.res = av | bv;
            3'b010:  it.res = s;
            3'b110:  it.res = s;
            3'b111:  it.res = W'($signed(av) < $signed(bv));
            default: it.res = '0;
        endcase
        it.z = (it.res == '0);
        sb_q.push_back(it);
    endtask

    function automatic string res_tag(input logic [2:0] o);
        case (o)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R6";
        endcase
    endfunction

    // Monitor: pop expectations and compare with the settled outputs.
    always @(negedge clk) begin
        item_t it;
        if (rst_n && sb_q.size() > 0) begin
            it = sb_q.pop_front();
            check(res_tag(it.op), "result", res, it.res);
            check("R7", "zero", W'(zero), W'(it.z));
            check("R8", "overflow", W'(ovf), W'(it.v));
            check("R3", "carry", W'(cout), W'(it.c));
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        a = '0; b = '0; op = 3'b000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "idle result", res, '0);
        check("R7", "idle zero", W'(zero), W'(1'b1));
        rst_n = 1'b1;

        // Logic patterns (R1, R2)
        drive(32'hF0F0_A5A5, 32'h0FF0_FFFF, 3'b000);
        drive(32'hF0F0_A5A5, 32'h0FF0_0000, 3'b001);
        drive(32'h0000_0000, 32'h0000_0000, 3'b001);
        // Addition boundaries (R3, R8)
        drive(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);
        drive(32'h8000_0000, 32'h8000_0000, 3'b010);
        drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
        drive(32'h7FFF_FFFF, 32'h8000_0000, 3'b010);
        // Subtraction boundaries (R4, R7, R8)
        drive(32'h8000_0000, 32'h0000_0001, 3'b110);
        drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
        drive(32'h1234_5678, 32'h1234_5678, 3'b110);
        drive(32'h0000_0000, 32'h0000_0001, 3'b110);
        // Signed compare including overflowing differences (R5)
        drive(32'h8000_0000, 32'h7FFF_FFFF, 3'b111);
        drive(32'h7FFF_FFFF, 32'h8000_0000, 3'b111);
        drive(32'h8000_0000, 32'h8000_0000, 3'b111);
        drive(32'h0000_0000, 32'h0000_0001, 3'b111);
        drive(32'hFFFF_FFFF, 32'h0000_0000, 3'b111);
        // Undefined codes with busy operands (R6)
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
        drive(32'hFFFF_FFFF, 32'h0000_0001, 3'b100);
        drive(32'h8000_0000, 32'h7FFF_FFFF, 3'b101);
        // Random operands across every code
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom();
            rb = (i % 7 == 0) ? ra : $urandom();
            if (i % 11 == 0) ra = 32'h8000_0000;
            if (i % 13 == 0) rb = 32'h7FFF_FFFF;
            drive(ra, rb, 3'(i % 8));
        end
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule